// File: doc/BRIEF.md
# Thermal Trip Shutdown Latch

This block turns a raw over-temperature comparator flag into a sticky, active-low trip indication and a matching request to stop all internal clocks. The flag crosses into the clock domain through a two-flop synchronizer. It must then stay high for a run of consecutive sampled cycles before it counts as a real over-temperature event. Brief glitches never shut the device down.

The power-good input is the block's only reset. While it is low, every output rests in its idle state. When it rises, an arming counter starts. Until that counter expires, the trip indication cannot be driven and the driver-enable output stays low. Once the trip fires, it stays latched until power-good drops. If the die is still hot when power-good returns, the trip fires again as soon as the arming window ends. The window length is computed from the clock frequency and a time in microseconds, and it must be no more than 10 µs.

Top module: `thermal_trip_guard`

## Requirements
- R1: While `pwr_ok` is low, `trip_n` is 1, `clk_stop` is 0 and `drv_en` is 0, whatever `hot_raw` does.
- R2: The arming window is ARM_CYCLES = (CLK_HZ / 1,000,000) * ARM_US clock edges. Counting the first rising clock edge with `pwr_ok` high as edge 1, `drv_en` is 0 after edge ARM_CYCLES-1 and 1 after edge ARM_CYCLES. It then stays 1 while `pwr_ok` stays high.
- R3: `trip_n` cannot go low while `drv_en` is 0, even if `hot_raw` is held high from the moment power-good rises.
- R4: `hot_raw` passes through SYNC_STAGES (2) flops and must then be seen high on FILT_LEN (2) consecutive samples. While armed, if `hot_raw` goes high just before edge 1 and stays high for at least FILT_LEN edges, `trip_n` is 1 after edge SYNC_STAGES+FILT_LEN and 0 after edge SYNC_STAGES+FILT_LEN+1.
- R5: A `hot_raw` pulse that is seen high on fewer than FILT_LEN consecutive edges never drives `trip_n` low.
- R6: Once `trip_n` is low, it stays low while `pwr_ok` stays high, even after `hot_raw` returns low.
- R7: `clk_stop` is always the inverse of `trip_n`.
- R8: When `pwr_ok` falls, the latched trip and the arming state clear at once, without waiting for a clock edge.
- R9: If `hot_raw` is still high when `pwr_ok` rises again, `trip_n` goes low after edge ARM_CYCLES+1 of the new power-good period.
- R10: A drop of `pwr_ok` during the arming window restarts the count: the next rise needs a full ARM_CYCLES edges before `drv_en` goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| pwr_ok | input | 1 | Power-good; low clears all state asynchronously |
| hot_raw | input | 1 | Asynchronous trip-level comparator flag, high means too hot |
| trip_n | output | 1 | Latched thermal trip, active low |
| clk_stop | output | 1 | Request to shut off all internal clocks |
| drv_en | output | 1 | High once the arming window has elapsed; trip output driver enable |

## Verification
There are three timing rules. A comparator change reaches `trip_n` on edge SYNC_STAGES+FILT_LEN+1, counted from the first edge that samples it. Arming completes on edge ARM_CYCLES after power-good rises, and a power-good drop clears the outputs before the next edge. The driver task drives inputs on falling edges. Each expectation goes into a scoreboard queue tagged with the exact rising edge at which it falls due. The monitor compares one time unit after that edge and checks the neighbouring edge as well, so a result that comes one cycle early or late is reported.

// File: rtl/thermtrip_pkg.sv
package thermtrip_pkg;

    // Number of clock cycles spanned by a window given in microseconds.
    function automatic int unsigned cycles_for_us(input int unsigned clk_hz,
                                                  input int unsigned us);
        int unsigned per_us;
        per_us = clk_hz / 1_000_000;
        if (per_us == 0) per_us = 1;
        return per_us * us;
    endfunction

    typedef struct packed {
        logic tripped;
    } trip_state_t;

endpackage

// File: rtl/tt_sync.sv
module tt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_t;

    sync_t s_d, s_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb s_d.sh = d_i;
        end else begin : g_chain
            always_comb s_d.sh = {s_q.sh[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q_o = s_q.sh[STAGES-1];
endmodule

// File: rtl/tt_filter.sv
module tt_filter #(
    parameter int LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic confirmed_o
);
    localparam int RW = $clog2(LEN + 1);

    typedef struct packed {
        logic [RW-1:0] run;
    } filt_t;

    filt_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (!level_i)
            f_d.run = '0;
        else if (f_q.run != RW'(LEN))
            f_d.run = f_q.run + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign confirmed_o = (f_q.run == RW'(LEN));
endmodule

// File: rtl/tt_arm_timer.sv
module tt_arm_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic armed_o
);
    localparam int CW = $clog2(CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } arm_t;

    arm_t a_d, a_q;

    always_comb begin
        a_d = a_q;
        if (a_q.cnt != CW'(CYCLES))
            a_d.cnt = a_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign armed_o = (a_q.cnt == CW'(CYCLES));
endmodule

// File: rtl/thermal_trip_guard.sv
module thermal_trip_guard
    import thermtrip_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 100_000_000,
    parameter int unsigned ARM_US      = 10,
    parameter int          SYNC_STAGES = 2,
    parameter int          FILT_LEN    = 2
) (
    input  logic clk,
    input  logic pwr_ok,
    input  logic hot_raw,
    output logic trip_n,
    output logic clk_stop,
    output logic drv_en
);
    localparam int ARM_CYCLES = int'(cycles_for_us(CLK_HZ, ARM_US));

    logic hot_sync;
    logic hot_confirmed;
    logic armed;

    tt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (pwr_ok),
        .d_i   (hot_raw),
        .q_o   (hot_sync)
    );

    tt_filter #(.LEN(FILT_LEN)) u_filter (
        .clk         (clk),
        .rst_n       (pwr_ok),
        .level_i     (hot_sync),
        .confirmed_o (hot_confirmed)
    );

    tt_arm_timer #(.CYCLES(ARM_CYCLES)) u_arm (
        .clk     (clk),
        .rst_n   (pwr_ok),
        .armed_o (armed)
    );

    trip_state_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (armed && hot_confirmed)
            t_d.tripped = 1'b1;
    end

    always_ff @(posedge clk or negedge pwr_ok) begin
        if (!pwr_ok) t_q <= '0;
        else         t_q <= t_d;
    end

    assign trip_n   = ~t_q.tripped;
    assign clk_stop = t_q.tripped;
    assign drv_en   = armed;
endmodule

// File: rtl/thermal_trip_guard_chk.sv
module thermal_trip_guard_chk (
    input logic clk,
    input logic pwr_ok,
    input logic trip_n,
    input logic clk_stop,
    input logic drv_en
);
    always @(posedge clk) begin
        if (!pwr_ok)
            AST_IDLE_UNPOWERED: assert (trip_n && !clk_stop && !drv_en); // R1
    end

    AST_ARM_HOLDS: assert property (@(posedge clk) disable iff (!pwr_ok)
        drv_en |=> drv_en); // R2

    AST_NO_TRIP_UNARMED: assert property (@(posedge clk) disable iff (!pwr_ok)
        !drv_en |-> trip_n); // R3

    AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (!pwr_ok)
        !trip_n |=> !trip_n); // R6

    AST_KILL_MATCHES_TRIP: assert property (@(posedge clk) disable iff (!pwr_ok)
        clk_stop == !trip_n); // R7
endmodule

bind thermal_trip_guard thermal_trip_guard_chk u_chk (
    .clk      (clk),
    .pwr_ok   (pwr_ok),
    .trip_n   (trip_n),
    .clk_stop (clk_stop),
    .drv_en   (drv_en)
);

// File: tb/thermal_trip_guard_test.sv
module thermal_trip_guard_test;
    localparam int CLK_PERIOD = 10;
    localparam int unsigned TB_CLK_HZ = 2_000_000;
    localparam int unsigned TB_ARM_US = 10;
    localparam int ARM = 20;   // (2 MHz / 1 MHz) * 10 us
    localparam int LAT = 5;    // 2 sync + 2 filter + 1 latch

    logic clk = 1'b0;
    logic pwr_ok;
    logic hot_raw;
    logic trip_n, clk_stop, drv_en;

    typedef struct {
        int    due;
        bit    tn;
        bit    ks;
        bit    en;
        string req;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    thermal_trip_guard #(
        .CLK_HZ (TB_CLK_HZ),
        .ARM_US (TB_ARM_US)
    ) uut (
        .clk      (clk),
        .pwr_ok   (pwr_ok),
        .hot_raw  (hot_raw),
        .trip_n   (trip_n),
        .clk_stop (clk_stop),
        .drv_en   (drv_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: pops items due at this edge and compares.
    always @(posedge clk) begin
        cyc = cyc + 1;
        #1;
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].due == cyc) begin
                checks++;
                if (trip_n !== q[i].tn || clk_stop !== q[i].ks || drv_en !== q[i].en) begin
                    errors++;
                    $display("FAIL %s at edge %0d: got trip_n=%b clk_stop=%b drv_en=%b, expected %b %b %b",
                             q[i].req, cyc, trip_n, clk_stop, drv_en, q[i].tn, q[i].ks, q[i].en);
                end
                q.delete(i);
            end
        end
    end

    task automatic expect_at(input int n, input bit tn, input bit ks, input bit en,
                             input string req);
        item_t it;
        it.due = cyc + n;
        it.tn  = tn;
        it.ks  = ks;
        it.en  = en;
        it.req = req;
        q.push_back(it);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        pwr_ok  = 1'b0;
        hot_raw = 1'b0;
        tick(2);
        expect_at(1, 1, 0, 0, "R1");
        hot_raw = 1'b1;
        tick(3);
        expect_at(1, 1, 0, 0, "R1");
        tick(2);

        // Arming window timing
        hot_raw = 1'b0;
        pwr_ok  = 1'b1;
        expect_at(ARM - 1, 1, 0, 0, "R2");
        expect_at(ARM,     1, 0, 1, "R2");
        tick(ARM + 2);

        // One-cycle glitch ignored
        hot_raw = 1'b1;
        tick(1);
        hot_raw = 1'b0;
        for (int k = 1; k <= 8; k++) expect_at(k, 1, 0, 1, "R5");
        tick(10);

        // Two-cycle pulse trips with fixed latency
        hot_raw = 1'b1;
        expect_at(LAT - 1, 1, 0, 1, "R4");
        expect_at(LAT,     0, 1, 1, "R4");
        tick(2);
        hot_raw = 1'b0;
        tick(4);
        expect_at(4, 0, 1, 1, "R6");
        expect_at(5, 0, 1, 1, "R7");
        tick(6);

        // Power-good drop clears at once
        hot_raw = 1'b1;
        pwr_ok  = 1'b0;
        expect_at(1, 1, 0, 0, "R8");
        tick(3);

        // Still hot on return: blocked until armed, then re-trips
        pwr_ok = 1'b1;
        expect_at(10,      1, 0, 0, "R3");
        expect_at(ARM,     1, 0, 1, "R3");
        expect_at(ARM + 1, 0, 1, 1, "R9");
        tick(ARM + 4);

        // Drop during arming restarts the count
        pwr_ok  = 1'b0;
        hot_raw = 1'b0;
        tick(2);
        pwr_ok = 1'b1;
        tick(10);
        pwr_ok = 1'b0;
        tick(1);
        pwr_ok = 1'b1;
        expect_at(ARM - 1, 1, 0, 0, "R10");
        expect_at(ARM,     1, 0, 1, "R10");
        tick(ARM + 3);

        // Sustained high while armed
        hot_raw = 1'b1;
        expect_at(LAT - 1, 1, 0, 1, "R4");
        expect_at(LAT,     0, 1, 1, "R4");
        tick(LAT + 3);

        while (q.size() != 0) tick(1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule